// File: doc/BRIEF.md
# Parallel-Port Nibble Byte Receiver

This block rebuilds 8-bit bytes that a host sends four bits at a time over a seven-line parallel bus. The bus is driven by host software, so it is asynchronous to the 50 MHz system clock and changes far more slowly than that clock. One line frames the transfer session and one line acts as a software-driven data strobe. Four lines carry a nibble, and the high half of each byte comes first.

All seven bus lines are first passed through a synchronizer. The control logic then watches the framing line, finds rising edges on the strobe line, and tracks whether the next nibble is the high half or the low half of a byte. The datapath stores the high nibble and joins it with the low nibble. It presents the byte with a one-cycle valid pulse and keeps a count of the bytes received in the current session. If a session closes after only one nibble of a byte has arrived, that nibble is dropped and the block raises a one-cycle error pulse.

Top module: `nibble_byte_rx`

## Requirements
- R1: After reset, byteOut, byteValid, abortPulse, sessionActive and byteCount are all 0.
- R2: A session opens, and sessionActive goes to 1, only when bus bit 2 rises while bits 6..3, 1 and 0 are all 0. Opening a session clears byteCount to 0. A rise of bit 2 while any other bit is 1 opens no session.
- R3: Nibbles are taken from bus bits 6..3, with bit 6 as the nibble's MSB. The first accepted strobe rise in a byte supplies byteOut[7:4] and the second supplies byteOut[3:0]. Falling edges of the strobe (bit 0) have no effect.
- R4: Each completed byte produces exactly one byteValid pulse lasting one cycle. byteOut holds its value until the next byte completes.
- R5: Strobe rises seen while no session is open change nothing: no byteValid pulse and no change to byteCount.
- R6: When bit 2 falls during a session, sessionActive goes to 0 and the next byte starts again at the high nibble. If one nibble of a byte is pending at that moment, it is discarded and abortPulse pulses for one cycle. If no nibble is pending, there is no pulse.
- R7: byteCount goes up by one for each completed byte, saturates at 2^CNT_W-1, and keeps its value after the session ends.
- R8: Each bus bit passes through SYNC_STAGES flops. With the default of 2, byteValid rises on the third clock edge after the strobe rise that completes a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portIn | input | 7 | Host bus: bit 0 strobe, bit 2 session enable, bits 6..3 nibble |
| byteOut | output | 8 | Last assembled byte |
| byteValid | output | 1 | One-cycle pulse when byteOut is updated |
| sessionActive | output | 1 | A transfer session is open |
| byteCount | output | CNT_W | Bytes received in the current or last session, saturating |
| abortPulse | output | 1 | One-cycle pulse when a half byte is discarded |

## Verification
The bench sends bytes whose two nibbles differ, such as 0xA5 against 0x5A, along with the values 0x00 and 0xFF. These show whether the nibbles are swapped, whether the bits inside a nibble are reversed, and whether any bit is stuck. It also sends a session-open pattern with a data bit set, and strobe toggles while no session is open. These separate a correct framing decode from a check that looks only at bit 2. A session that closes halfway through a byte and is followed by a full byte shows whether the nibble phase is reset. A long burst past the counter limit confirms that the count saturates instead of wrapping, and that the next session clears it.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int BUS_W      = 7;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 2 * NIB_W;
  localparam int STROBE_BIT = 0;
  localparam int ENABLE_BIT = 2;
  localparam int NIB_LSB    = 3;
  localparam int NIB_MSB    = NIB_LSB + NIB_W - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic clrCount;
  } dpCtrl_t;
endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/nbr_ctrl.sv
module nbr_ctrl
  import nbr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] syncBus,
  output dpCtrl_t          dpCtrl,
  output logic             sessionActive,
  output logic             abortPulse
);
  logic prevStrobe, prevEnable;
  logic activeQ, phaseLoQ, abortQ;
  logic enNow, othersZero, startEv, endEv, strobeRise, accept;

  always_comb begin
    enNow      = syncBus[ENABLE_BIT];
    othersZero = (syncBus[NIB_MSB:NIB_LSB] == '0) && (syncBus[1] == 1'b0)
                 && (syncBus[STROBE_BIT] == 1'b0);
    strobeRise = syncBus[STROBE_BIT] && !prevStrobe;
    startEv    = !activeQ && enNow && !prevEnable && othersZero;
    endEv      = activeQ && !enNow;
    accept     = activeQ && enNow && strobeRise;
  end

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.clrCount = startEv;
    dpCtrl.loadHi   = accept && !phaseLoQ;
    dpCtrl.loadLo   = accept && phaseLoQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStrobe <= 1'b0;
      prevEnable <= 1'b0;
      activeQ    <= 1'b0;
      phaseLoQ   <= 1'b0;
      abortQ     <= 1'b0;
    end else begin
      prevStrobe <= syncBus[STROBE_BIT];
      prevEnable <= enNow;
      abortQ     <= 1'b0;
      if (endEv) begin
        activeQ  <= 1'b0;
        phaseLoQ <= 1'b0;
        abortQ   <= phaseLoQ;
      end else if (startEv) begin
        activeQ  <= 1'b1;
        phaseLoQ <= 1'b0;
      end else if (accept) begin
        phaseLoQ <= !phaseLoQ;
      end
    end
  end

  assign sessionActive = activeQ;
  assign abortPulse    = abortQ;
endmodule

// File: rtl/nbr_datapath.sv
module nbr_datapath
  import nbr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  nibIn,
  input  dpCtrl_t           dpCtrl,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic [CNT_W-1:0]  byteCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NIB_W-1:0]  hiNib;
  logic [BYTE_W-1:0] byteQ;
  logic              validQ;
  logic [CNT_W-1:0]  countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib  <= '0;
      byteQ  <= '0;
      validQ <= 1'b0;
      countQ <= '0;
    end else begin
      validQ <= 1'b0;
      if (dpCtrl.loadHi) hiNib <= nibIn;
      if (dpCtrl.loadLo) begin
        byteQ  <= {hiNib, nibIn};
        validQ <= 1'b1;
      end
      if (dpCtrl.clrCount)
        countQ <= '0;
      else if (dpCtrl.loadLo && countQ != CNT_MAX)
        countQ <= countQ + 1'b1;
    end
  end

  assign byteOut   = byteQ;
  assign byteValid = validQ;
  assign byteCount = countQ;
endmodule

// File: rtl/nibble_byte_rx.sv
module nibble_byte_rx
  import nbr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [6:0]       portIn,
  output logic [7:0]       byteOut,
  output logic             byteValid,
  output logic             sessionActive,
  output logic [CNT_W-1:0] byteCount,
  output logic             abortPulse
);
  logic [BUS_W-1:0] syncBus;
  dpCtrl_t          dpCtrl;

  nbr_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(portIn), .syncOut(syncBus)
  );

  nbr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncBus(syncBus), .dpCtrl(dpCtrl),
    .sessionActive(sessionActive), .abortPulse(abortPulse)
  );

  nbr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .nibIn(syncBus[NIB_MSB:NIB_LSB]), .dpCtrl(dpCtrl),
    .byteOut(byteOut), .byteValid(byteValid), .byteCount(byteCount)
  );
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             sessionActive,
  input logic [CNT_W-1:0] byteCount,
  input logic             abortPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_valid_in_session_R5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(sessionActive));

  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  assert_abort_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !sessionActive);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sessionActive) |-> byteCount == '0);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && $past(byteCount) != CNT_MAX) |-> byteCount == $past(byteCount) + 1'b1);

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !$rose(sessionActive)) |-> $stable(byteCount));
endmodule

bind nibble_byte_rx nbr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .sessionActive(sessionActive),
  .byteCount(byteCount), .abortPulse(abortPulse)
);

// File: tb/nibble_byte_rx_bench.sv
module nibble_byte_rx_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [6:0]       portIn = '0;
  logic [7:0]       byteOut;
  logic             byteValid, sessionActive, abortPulse;
  logic [CNT_W-1:0] byteCount;

  int tests = 0, fails = 0;
  int rxCount = 0, abortCount = 0;
  logic [7:0] lastRx = '0;

  always #2 clk = ~clk;

  nibble_byte_rx u_nibble_byte_rx (
    .clk(clk), .rstN(rstN), .portIn(portIn), .byteOut(byteOut),
    .byteValid(byteValid), .sessionActive(sessionActive),
    .byteCount(byteCount), .abortPulse(abortPulse)
  );

  always @(negedge clk) begin
    if (rstN && byteValid) begin
      rxCount = rxCount + 1;
      lastRx  = byteOut;
    end
    if (rstN && abortPulse) abortCount = abortCount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v, input int hold);
    @(negedge clk);
    portIn = v;
    repeat (hold) @(negedge clk);
  endtask

  function automatic int rh();
    return int'($urandom_range(6, 20));
  endfunction

  task automatic openSession();  drive(7'b0000100, rh()); endtask
  task automatic closeSession(); drive(7'b0000000, rh()); endtask

  task automatic sendNib(input logic [3:0] n, input int hold);
    drive({n, 3'b100}, hold);
    drive({n, 3'b101}, hold);
  endtask

  task automatic sendByte(input logic [7:0] b, input int hold);
    sendNib(b[7:4], hold);
    sendNib(b[3:0], hold);
  endtask

  task automatic t_reset();
    check(byteOut == 0 && !byteValid && !abortPulse, "R1 data outputs", byteOut, 0);
    check(!sessionActive && byteCount == 0, "R1 session/count", byteCount, 0);
  endtask

  task automatic t_latency();
    openSession();
    check(sessionActive && byteCount == 0, "R2 open", sessionActive, 1);
    sendNib(4'h9, 8);
    drive(7'b0110100, 8);
    @(negedge clk);
    portIn = 7'b0110101;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(byteValid == (k == 3), "R8 valid latency", byteValid, (k == 3));
    end
    check(byteOut == 8'h96, "R3 first byte", byteOut, 8'h96);
    repeat (10) @(negedge clk);
    closeSession();
  endtask

  task automatic t_bytes();
    logic [7:0] vals [6] = '{8'hA5, 8'h5A, 8'h00, 8'hFF, 8'h1B, 8'h34};
    int base;
    openSession();
    base = rxCount;
    for (int i = 0; i < 6; i++) begin
      sendByte(vals[i], rh());
      check(lastRx == vals[i], "R3 byte order", lastRx, vals[i]);
      check(rxCount == base + i + 1, "R4 one pulse per byte", rxCount - base, i + 1);
    end
    check(byteCount == 6, "R7 count", byteCount, 6);
    repeat (30) @(negedge clk);
    check(byteOut == 8'h34, "R4 byteOut held", byteOut, 8'h34);
    closeSession();
    check(abortCount == 0, "R6 clean close no abort", abortCount, 0);
    check(!sessionActive, "R6 session closed", sessionActive, 0);
  endtask

  task automatic t_ignored();
    int base = rxCount;
    for (int i = 0; i < 4; i++) begin
      drive(7'b1010001, rh());
      drive(7'b1010000, rh());
    end
    check(rxCount == base, "R5 no byte outside session", rxCount - base, 0);
    check(byteCount == 6, "R5/R7 count kept", byteCount, 6);
    check(!sessionActive, "R5 idle", sessionActive, 0);
  endtask

  task automatic t_badStart();
    drive(7'b0100100, rh());
    check(!sessionActive, "R2 dirty start rejected", sessionActive, 0);
    check(byteCount == 6, "R2 count untouched", byteCount, 6);
    closeSession();
    openSession();
    check(sessionActive && byteCount == 0, "R2 clean start clears", byteCount, 0);
  endtask

  task automatic t_abort();
    int base = rxCount;
    sendNib(4'hE, rh());
    closeSession();
    check(abortCount == 1, "R6 abort pulse", abortCount, 1);
    check(rxCount == base, "R6 half byte dropped", rxCount - base, 0);
    openSession();
    sendByte(8'h3C, rh());
    check(lastRx == 8'h3C, "R6 phase reset", lastRx, 8'h3C);
    closeSession();
    check(abortCount == 1, "R6 no extra abort", abortCount, 1);
  endtask

  task automatic t_saturate();
    openSession();
    for (int i = 0; i < 260; i++) sendByte(8'(i), 4);
    check(byteCount == 8'hFF, "R7 saturate", byteCount, 8'hFF);
    check(lastRx == 8'(259), "R3 burst last byte", lastRx, 8'(259));
    closeSession();
    openSession();
    check(byteCount == 0, "R7 cleared on new session", byteCount, 0);
    closeSession();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_latency();
    t_bytes();
    t_ignored();
    t_badStart();
    t_abort();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule